// File: doc/BRIEF.md
# Bit-Addressable Internal Data Memory

This block is the on-chip data store of a small 8-bit controller core. It holds 128 general-purpose bytes in the lower half of an 8-bit address space. The upper half is a sparse set of 21 special function registers. One port serves both byte accesses and single-bit accesses. A bit-mode flag selects how the address is interpreted.

In byte mode the address picks a byte directly. Reads and writes are sampled on the rising clock edge. In bit mode the address is first decoded into a byte location and a bit index. A bit write then becomes a read-modify-write of that byte. A bit read returns one bit on a separate 1-bit output, and the byte output is left as it was. A synchronous reset clears all storage.

Top module: `iram_bitmem`

## Requirements
- R1: While `rst` is high at a rising edge, all storage is cleared to 00h. Any read or write presented in that cycle is ignored, and `rdata` and `bit_rdata` hold their previous values.
- R2: A byte write (`wr_en`=1, `bit_mode`=0) stores `wdata` at `addr` on the rising edge. A byte read (`rd_en`=1, `bit_mode`=0) loads the addressed byte into `rdata` on the rising edge where it is sampled.
- R3: `rdata` changes only after a byte read. `bit_rdata` changes only after a bit read (`rd_en`=1, `bit_mode`=1).
- R4: A bit address below 80h selects byte 20h + `addr[6:3]` and bit index `addr[2:0]`, where bit 0 is the LSB.
- R5: A bit write replaces only the selected bit with `bit_wdata`. The other seven bits of that byte keep their value.
- R6: A bit address of 80h or above selects the register at {`addr[7:3]`,000b} and bit index `addr[2:0]`. A register whose address is not a multiple of 8 cannot be reached in bit mode. If the selected slot has no register, a bit read returns 0 and a bit write has no effect.
- R7: The implemented registers sit at these addresses: 80h–83h, 87h, 88h–8Dh, 90h, 98h, 99h, A0h, A8h, B0h, B8h, D0h, E0h and F0h. A byte read of any other address from 80h up returns 00h, and a write to it is ignored.
- R8: When `rd_en` and `wr_en` are both high in one cycle, the write takes effect and the read returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 8 | Byte address, or bit address when `bit_mode`=1 |
| wdata | input | 8 | Byte write data |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| bit_mode | input | 1 | Selects a single-bit access |
| bit_wdata | input | 1 | Bit write data |
| rdata | output | 8 | Registered byte read data |
| bit_rdata | output | 1 | Registered bit read data |

## Verification
The main function is exercised with byte write-then-read pairs to general bytes, implemented registers and unimplemented register addresses. These pairs separate real storage from the 00h returned for empty slots. Bit writes of 1 into zeroed bytes and of 0 into all-ones bytes show that exactly one bit moves, and they confirm the index decode in both halves of the space. Bit reads follow byte reads and the reverse, which shows that each output holds while the other path is used. Two further tests cover a combined read-and-write cycle and a reset that carries active strobes.

// File: rtl/iram_bitmem.sv
module iram_bitmem #(
  parameter int GP_BYTES  = 128,
  parameter int SFR_COUNT = 21,
  parameter logic [7:0] BIT_BASE = 8'h20
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  input  logic       rd_en,
  input  logic       wr_en,
  input  logic       bit_mode,
  input  logic       bit_wdata,
  output logic [7:0] rdata,
  output logic       bit_rdata
);
  localparam int GPW = $clog2(GP_BYTES);
  localparam int SW  = $clog2(SFR_COUNT);

  logic [7:0] gp  [GP_BYTES];
  logic [7:0] sfr [SFR_COUNT];

  function automatic logic [SW:0] sfr_slot(input logic [7:0] a);
    case (a)
      8'h80: return {1'b1, SW'(0)};
      8'h81: return {1'b1, SW'(1)};
      8'h82: return {1'b1, SW'(2)};
      8'h83: return {1'b1, SW'(3)};
      8'h87: return {1'b1, SW'(4)};
      8'h88: return {1'b1, SW'(5)};
      8'h89: return {1'b1, SW'(6)};
      8'h8A: return {1'b1, SW'(7)};
      8'h8B: return {1'b1, SW'(8)};
      8'h8C: return {1'b1, SW'(9)};
      8'h8D: return {1'b1, SW'(10)};
      8'h90: return {1'b1, SW'(11)};
      8'h98: return {1'b1, SW'(12)};
      8'h99: return {1'b1, SW'(13)};
      8'hA0: return {1'b1, SW'(14)};
      8'hA8: return {1'b1, SW'(15)};
      8'hB0: return {1'b1, SW'(16)};
      8'hB8: return {1'b1, SW'(17)};
      8'hD0: return {1'b1, SW'(18)};
      8'hE0: return {1'b1, SW'(19)};
      8'hF0: return {1'b1, SW'(20)};
      default: return '0;
    endcase
  endfunction

  logic [7:0]  byte_addr;
  logic [2:0]  bit_idx;
  logic [SW:0] slot;
  logic        is_gp, sfr_hit;
  logic [7:0]  cur, merged, wval;

  assign byte_addr = !bit_mode ? addr :
                     addr[7]   ? {addr[7:3], 3'b000} :
                                 BIT_BASE + {4'd0, addr[6:3]};
  assign bit_idx = addr[2:0];
  assign slot    = sfr_slot(byte_addr);
  assign sfr_hit = slot[SW];
  assign is_gp   = !byte_addr[7];
  assign cur     = is_gp ? gp[byte_addr[GPW-1:0]] :
                   sfr_hit ? sfr[slot[SW-1:0]] : 8'h00;

  always_comb begin
    merged = cur;
    merged[bit_idx] = bit_wdata;
  end

  assign wval = bit_mode ? merged : wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < GP_BYTES; i++) gp[i] <= 8'h00;
      for (int j = 0; j < SFR_COUNT; j++) sfr[j] <= 8'h00;
    end else begin
      if (wr_en) begin
        if (is_gp) gp[byte_addr[GPW-1:0]] <= wval;
        else if (sfr_hit) sfr[slot[SW-1:0]] <= wval;
      end
      if (rd_en && !bit_mode) rdata <= cur;
      if (rd_en && bit_mode) bit_rdata <= cur[bit_idx];
    end
  end
endmodule

module iram_bitmem_chk (
  input logic       clk,
  input logic       rst,
  input logic [7:0] addr,
  input logic [7:0] wdata,
  input logic       rd_en,
  input logic       wr_en,
  input logic       bit_mode,
  input logic [7:0] rdata,
  input logic       bit_rdata
);
  // R1
  reset_hold_chk: assert property (@(posedge clk) disable iff (1'b0)
    $past(rst) |-> $stable(rdata));

  // R3
  byte_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && !bit_mode) |=> $stable(rdata));

  // R3
  bit_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && bit_mode) |=> $stable(bit_rdata));

  // R2
  write_read_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !bit_mode && !addr[7] ##1
     rd_en && !wr_en && !bit_mode && addr == $past(addr))
    |=> rdata == $past(wdata, 2));

  // R7
  empty_sfr_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en && !bit_mode && addr == 8'hC0 |=> rdata == 8'h00);

  // R6
  empty_bit_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en && bit_mode && addr[7:3] == 5'b11000 |=> !bit_rdata);
endmodule

bind iram_bitmem iram_bitmem_chk u_chk (
  .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .rd_en(rd_en),
  .wr_en(wr_en), .bit_mode(bit_mode), .rdata(rdata), .bit_rdata(bit_rdata)
);

// File: tb/iram_bitmem_test.sv
module iram_bitmem_test;
  logic clk = 0, rst = 1;
  logic [7:0] addr = 0, wdata = 0;
  logic rd_en = 0, wr_en = 0, bit_mode = 0, bit_wdata = 0;
  logic [7:0] rdata;
  logic bit_rdata;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  iram_bitmem uut (.clk(clk), .rst(rst), .addr(addr), .wdata(wdata),
    .rd_en(rd_en), .wr_en(wr_en), .bit_mode(bit_mode), .bit_wdata(bit_wdata),
    .rdata(rdata), .bit_rdata(bit_rdata));

  typedef struct packed {
    logic wr, rd, bm, bw;
    logic [7:0] a, d, er;
    logic eb;
  } vec_t;

  localparam int NV = 35;
  localparam vec_t VEC [NV] = '{
    '{1'b1,1'b0,1'b0,1'b0,8'h05,8'hA5,8'h00,1'b0},
    '{1'b0,1'b1,1'b0,1'b0,8'h05,8'h00,8'hA5,1'b0},
    '{1'b1,1'b0,1'b0,1'b0,8'h7F,8'h3C,8'h00,1'b0},
    '{1'b0,1'b1,1'b0,1'b0,8'h7F,8'h00,8'h3C,1'b0},
    '{1'b1,1'b0,1'b0,1'b0,8'hE0,8'h81,8'h00,1'b0},
    '{1'b0,1'b1,1'b0,1'b0,8'hE0,8'h00,8'h81,1'b0},
    '{1'b1,1'b0,1'b0,1'b0,8'hF0,8'h42,8'h00,1'b0},
    '{1'b0,1'b1,1'b0,1'b0,8'hF0,8'h00,8'h42,1'b0},
    '{1'b1,1'b0,1'b0,1'b0,8'hC0,8'h55,8'h00,1'b0},
    '{1'b0,1'b1,1'b0,1'b0,8'hC0,8'h00,8'h00,1'b0},
    '{1'b1,1'b0,1'b0,1'b0,8'h21,8'h00,8'h00,1'b0},
    '{1'b1,1'b0,1'b1,1'b1,8'h0B,8'h00,8'h00,1'b0},
    '{1'b0,1'b1,1'b0,1'b0,8'h21,8'h00,8'h08,1'b0},
    '{1'b0,1'b1,1'b1,1'b0,8'h0B,8'h00,8'h00,1'b1},
    '{1'b0,1'b1,1'b1,1'b0,8'h0A,8'h00,8'h00,1'b0},
    '{1'b1,1'b0,1'b0,1'b0,8'h2F,8'hFF,8'h00,1'b0},
    '{1'b1,1'b0,1'b1,1'b0,8'h7F,8'h00,8'h00,1'b0},
    '{1'b0,1'b1,1'b0,1'b0,8'h2F,8'h00,8'h7F,1'b0},
    '{1'b1,1'b0,1'b1,1'b1,8'hE3,8'h00,8'h00,1'b0},
    '{1'b0,1'b1,1'b0,1'b0,8'hE0,8'h00,8'h89,1'b0},
    '{1'b0,1'b1,1'b1,1'b0,8'hD7,8'h00,8'h00,1'b0},
    '{1'b1,1'b0,1'b0,1'b0,8'hD0,8'h80,8'h00,1'b0},
    '{1'b0,1'b1,1'b1,1'b0,8'hD7,8'h00,8'h00,1'b1},
    '{1'b1,1'b0,1'b1,1'b1,8'hC5,8'h00,8'h00,1'b0},
    '{1'b0,1'b1,1'b1,1'b0,8'hC5,8'h00,8'h00,1'b0},
    '{1'b1,1'b0,1'b0,1'b0,8'h90,8'hFF,8'h00,1'b0},
    '{1'b1,1'b0,1'b1,1'b0,8'h92,8'h00,8'h00,1'b0},
    '{1'b0,1'b1,1'b0,1'b0,8'h90,8'h00,8'hFB,1'b0},
    '{1'b1,1'b0,1'b0,1'b0,8'h84,8'h77,8'h00,1'b0},
    '{1'b0,1'b1,1'b0,1'b0,8'h84,8'h00,8'h00,1'b0},
    '{1'b1,1'b0,1'b0,1'b0,8'h83,8'h5A,8'h00,1'b0},
    '{1'b0,1'b1,1'b0,1'b0,8'h83,8'h00,8'h5A,1'b0},
    '{1'b1,1'b0,1'b1,1'b1,8'h81,8'h00,8'h00,1'b0},
    '{1'b0,1'b1,1'b0,1'b0,8'h81,8'h00,8'h00,1'b0},
    '{1'b0,1'b1,1'b0,1'b0,8'h80,8'h00,8'h02,1'b0}
  };

  task automatic apply(input logic w, r, bm, bw, input logic [7:0] a, d);
    @(negedge clk);
    wr_en = w; rd_en = r; bit_mode = bm; bit_wdata = bw; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 0; rd_en = 0; bit_mode = 0;
  endtask

  task automatic chk8(input string req, input logic [7:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk1(input string req, input logic act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] last_b;
    logic last_bit, bit_seen;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;

    // R1 reset state
    apply(0, 1, 0, 0, 8'h05, 0); chk8("R1 reset gp", rdata, 8'h00);
    apply(0, 1, 0, 0, 8'hE0, 0); chk8("R1 reset sfr", rdata, 8'h00);
    last_b = 8'h00; bit_seen = 0; last_bit = 0;

    // R2 R3 R4 R5 R6 R7 table
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i].wr, VEC[i].rd, VEC[i].bm, VEC[i].bw, VEC[i].a, VEC[i].d);
      if (VEC[i].rd && !VEC[i].bm) begin
        chk8($sformatf("R2/R4-R7 vec %0d", i), rdata, VEC[i].er);
        last_b = VEC[i].er;
      end else
        chk8($sformatf("R3 byte hold vec %0d", i), rdata, last_b);
      if (VEC[i].rd && VEC[i].bm) begin
        chk1($sformatf("R4/R6 bit vec %0d", i), bit_rdata, VEC[i].eb);
        last_bit = VEC[i].eb; bit_seen = 1;
      end else if (bit_seen)
        chk1($sformatf("R3 bit hold vec %0d", i), bit_rdata, last_bit);
    end

    // R8 read and write together: old value returned, write lands
    apply(1, 1, 0, 0, 8'h05, 8'h11); chk8("R8 old value", rdata, 8'hA5);
    apply(0, 1, 0, 0, 8'h05, 0);     chk8("R8 new value", rdata, 8'h11);
    apply(0, 1, 1, 0, 8'h0B, 0);     chk1("R8 bit before reset", bit_rdata, 1'b1);

    // R1 reset with active strobes
    @(negedge clk); rst = 1; wr_en = 1; rd_en = 1; addr = 8'h05; wdata = 8'h99;
    @(posedge clk); #1; chk8("R1 hold rdata in reset", rdata, 8'h11);
    @(negedge clk); bit_mode = 1; bit_wdata = 0; addr = 8'h0A;
    @(posedge clk); #1; chk1("R1 hold bit_rdata in reset", bit_rdata, 1'b1);
    @(negedge clk); rst = 0; wr_en = 0; rd_en = 0; bit_mode = 0;
    apply(0, 1, 0, 0, 8'h05, 0); chk8("R1 cleared 05", rdata, 8'h00);
    apply(0, 1, 0, 0, 8'h90, 0); chk8("R1 cleared 90", rdata, 8'h00);
    apply(0, 1, 1, 0, 8'h0B, 0); chk1("R1 cleared bit 0B", bit_rdata, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule